// File: doc/BRIEF.md
# Slave-FIFO Downstream Read Engine

This block empties the downstream endpoint of an external USB controller that exposes its endpoint buffers as an asynchronous slave FIFO. While the controller reports that the endpoint holds data, and the on-chip receive queue has room, the engine asks a bus arbiter for the shared pins. Once it holds them, it pulls bytes off the 8-bit data bus one strobe cycle at a time and writes each byte into the receive queue.

Every strobe edge falls on a clock cycle that a clock-enable tick from an external divider has opened. The divider keeps the strobe rate within the controller's 48 MHz limit. For each byte, output-enable and read go low together. The data bus is captured halfway through the low phase, and the strobes are then raised again. After a fixed high phase, the engine looks at the synchronised empty flag and the queue-full input again and decides whether to read another byte or give the bus back.

The engine never drives the data pins. The receive queue it feeds is expected to hold at least 512 bytes.

Top module: `slvfifo_rd_engine`

## Requirements
- R1: During and right after reset, `oe_n` and `rd_n` are 1, and `bus_req` and `rxq_wr` are 0.
- R2: A strobe low phase starts only if the two-flop-synchronised `ep_empty_n` read 1 (endpoint holds data; 0 means empty). While the endpoint is empty, no strobe falls and `bus_req` stays 0. The number of strobe cycles equals the number of bytes the endpoint held.
- R3: No strobe low phase starts while `rxq_full` is 1. If `rxq_full` rises during a burst, no further byte is read until it falls.
- R4: `bus_req` goes to 1 before any strobe falls, and the strobes are low only while both `bus_req` and `bus_gnt` are 1.
- R5: `fifo_addr` carries 2'b00, which selects the downstream endpoint. After `bus_gnt` is first seen, at least one full tick period passes before the first strobe falls.
- R6: `oe_n` and `rd_n` fall in the same clock cycle and rise in the same clock cycle.
- R7: Each byte is captured from `data_in` at the first tick after the strobes fall, which is half of a two-tick low phase. It is delivered on `rxq_data` with a one-cycle `rxq_wr` pulse while the strobes are still low. Bytes arrive in endpoint order, with none lost and none repeated.
- R8: The strobes stay low for exactly `LOW_TICKS` ticks (default 2). Between two bytes they stay high for at least `REL_TICKS` ticks (default 2).
- R9: Every strobe edge happens in the cycle after a clock edge at which `tick` was 1.
- R10: Once the endpoint is empty or `rxq_full` is 1 at the end of a high phase, the engine drops `bus_req` and reads no more bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock-enable from the strobe-rate divider |
| ep_empty_n | input | 1 | Asynchronous endpoint flag, 0 = empty |
| bus_gnt | input | 1 | Shared-bus grant from the arbiter |
| data_in | input | 8 | Slave-FIFO data bus (input only) |
| rxq_full | input | 1 | Receive queue cannot take a byte |
| bus_req | output | 1 | Shared-bus request to the arbiter |
| fifo_addr | output | 2 | Endpoint select, 2'b00 |
| oe_n | output | 1 | Output-enable strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| rxq_wr | output | 1 | One-cycle write pulse to the receive queue |
| rxq_data | output | 8 | Byte written to the receive queue |

## Verification
The assertions rely on four properties of the inputs:
- The arbiter keeps `bus_gnt` high for as long as `bus_req` is held.
- The controller keeps `data_in` stable while the strobes are low.
- The controller updates `ep_empty_n` soon enough after a strobe rises that the synchronised copy is settled before the high phase ends.
- `tick` is a regular clock-enable.

The bench stays within these limits. Its arbiter model grants only while a request is up and withdraws only after the request drops. Its controller model changes the data and the flag only on the rising read edge. Its tick fires every third clock, so the six-clock high phase covers the two-flop synchroniser delay.

// File: rtl/usbrx_pkg.sv
// Package: shared types and constants of the slave-FIFO read engine.
// Assumes: included first in compile order.
package usbrx_pkg;

    // Read engine phases
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_SETUP = 3'd2,
        ST_LOW   = 3'd3,
        ST_REL   = 3'd4
    } rd_state_t;

    // Address that selects the downstream endpoint on the slave FIFO
    localparam logic [1:0] EP_DOWN_ADDR = 2'b00;

endpackage

// File: rtl/rx_flag_sync.sv
// Module: rx_flag_sync
// Brings an asynchronous level flag into the clk domain through a chain
// of STAGES flops. Resets to 0 (the safe "endpoint empty" reading).
// Assumes: the flag is a level that stays stable for several clocks.
module rx_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the flag through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/rx_phase_cnt.sv
// Module: rx_phase_cnt
// Counts ticks within one engine phase. Clearing takes priority over
// stepping, so a phase always starts from zero.
// Assumes: the owner clears it on every phase change.
module rx_phase_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt
);

    // Tick counter with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rx_read_fsm.sv
// Module: rx_read_fsm
// Sequences one slave-FIFO read at a time:
//   request the bus, wait one address-setup tick, hold the strobes low for
//   LOW_TICKS ticks (capturing the data bus after half of them), then hold
//   the strobes high for REL_TICKS ticks before deciding on the next byte.
// Assumes: flag_ok is already synchronised; bus_gnt stays high while
// bus_req is high; LOW_TICKS is even and at least 2; REL_TICKS >= 1.
module rx_read_fsm
    import usbrx_pkg::*;
#(
    parameter int LOW_TICKS = 2,
    parameter int REL_TICKS = 2,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          flag_ok,
    input  logic          rxq_full,
    input  logic          bus_gnt,
    input  logic [DW-1:0] data_in,
    output logic          bus_req,
    output logic          strobe_n,
    output logic          rxq_wr,
    output logic [DW-1:0] rxq_data
);

    localparam int MAXP    = (LOW_TICKS > REL_TICKS) ? LOW_TICKS : REL_TICKS;
    localparam int CW      = $clog2(MAXP) + 1;
    localparam int HALF    = LOW_TICKS / 2;
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_TICKS - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_TICKS - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

    rd_state_t     state, state_nx;
    logic [CW-1:0] ph_cnt;
    logic          go_ok;
    logic          sample;

    assign go_ok  = flag_ok && !rxq_full;
    assign sample = tick && (state == ST_LOW) && (ph_cnt == HALF_LAST);

    // Phase tick counter, restarted on every state change
    rx_phase_cnt #(.W(CW)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick && (state_nx != state)),
        .step (tick),
        .cnt  (ph_cnt)
    );

    // Next-state decision, evaluated only on divider ticks
    always_comb begin
        state_nx = state;
        if (tick) begin
            unique case (state)
                ST_IDLE:  if (go_ok) state_nx = ST_REQ;
                ST_REQ: begin
                    if (!go_ok)       state_nx = ST_IDLE;
                    else if (bus_gnt) state_nx = ST_SETUP;
                end
                ST_SETUP: state_nx = (go_ok && bus_gnt) ? ST_LOW : ST_IDLE;
                ST_LOW:   if (ph_cnt == LOW_LAST) state_nx = ST_REL;
                ST_REL: begin
                    if (ph_cnt == REL_LAST)
                        state_nx = (go_ok && bus_gnt) ? ST_LOW : ST_IDLE;
                end
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the data bus mid-strobe and pulse the queue write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxq_wr   <= 1'b0;
            rxq_data <= '0;
        end else begin
            rxq_wr <= sample;
            if (sample) rxq_data <= data_in;
        end
    end

    assign strobe_n = (state != ST_LOW);
    assign bus_req  = (state != ST_IDLE);

    // A low phase only opens on a non-empty synchronised flag
    p_no_read_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> $past(flag_ok));

    // A low phase never opens while the receive queue is full
    p_no_read_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> !$past(rxq_full));

    // The queue write lands while the strobes are still low
    p_push_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_wr |-> !strobe_n);

endmodule

// File: rtl/slvfifo_rd_engine.sv
// Module: slvfifo_rd_engine (top)
// Drains the downstream endpoint of an asynchronous slave-FIFO USB
// controller into an internal receive queue. It synchronises the empty
// flag, arbitrates for the shared pins, and drives paired active-low
// output-enable and read strobes paced by the divider tick.
// Assumes: data pins are inputs only here; the endpoint address is fixed.
module slvfifo_rd_engine
    import usbrx_pkg::*;
#(
    parameter int LOW_TICKS   = 2,
    parameter int REL_TICKS   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ep_empty_n,
    input  logic          bus_gnt,
    input  logic [DW-1:0] data_in,
    input  logic          rxq_full,
    output logic          bus_req,
    output logic [1:0]    fifo_addr,
    output logic          oe_n,
    output logic          rd_n,
    output logic          rxq_wr,
    output logic [DW-1:0] rxq_data
);

    logic flag_ok;
    logic strobe_n;

    // Empty flag into the clock domain
    rx_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ep_empty_n),
        .sync_out(flag_ok)
    );

    // Read sequencer
    rx_read_fsm #(
        .LOW_TICKS(LOW_TICKS),
        .REL_TICKS(REL_TICKS),
        .DW       (DW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .flag_ok (flag_ok),
        .rxq_full(rxq_full),
        .bus_gnt (bus_gnt),
        .data_in (data_in),
        .bus_req (bus_req),
        .strobe_n(strobe_n),
        .rxq_wr  (rxq_wr),
        .rxq_data(rxq_data)
    );

    assign fifo_addr = EP_DOWN_ADDR;
    assign oe_n      = strobe_n;
    assign rd_n      = strobe_n;

    // Strobes are low only while this engine owns the bus
    p_grant_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (bus_req && bus_gnt));

    // Strobe edges follow a divider tick
    p_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_n) |-> $past(tick));

    // A strobe never falls without a grant seen on the previous edge
    p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(bus_gnt));

endmodule

// File: tb/slvfifo_rd_engine_bench.sv
// Bench: scoreboard around slvfifo_rd_engine. A loader task fills a model
// endpoint and queues the expected bytes; a negedge monitor pops and
// compares them and times the strobes.
module slvfifo_rd_engine_bench;

    localparam int TICK_DIV = 3;
    localparam int LOWT     = 2;
    localparam int RELT     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ep_empty_n;
    logic       bus_gnt = 1'b0;
    logic [7:0] data_in;
    logic       rxq_full = 1'b0;
    logic       bus_req;
    logic [1:0] fifo_addr;
    logic       oe_n, rd_n, rxq_wr;
    logic [7:0] rxq_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Endpoint model
    logic [7:0] ep_mem [0:1023];
    int ep_wr = 0;
    int ep_rd = 0;
    logic [7:0] exp_q [$];

    // Monitor state
    int tick_cnt = 0;
    int req_age = 0;
    int gnt_delay = 2;
    int gnt_age = 0;
    int low_len = 0;
    int hi_len = 0;
    int falls = 0;
    int pushes = 0;
    bit prev_rd = 1'b1;
    bit seen_fall = 0;

    always #2 clk = ~clk;

    assign ep_empty_n = (ep_wr != ep_rd);
    assign data_in    = ep_mem[ep_rd % 1024];

    // Controller pops its FIFO on the rising read edge
    always @(posedge rd_n) if (rst_n && ep_rd != ep_wr) ep_rd++;

    slvfifo_rd_engine u_slvfifo_rd_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ep_empty_n(ep_empty_n),
        .bus_gnt(bus_gnt), .data_in(data_in), .rxq_full(rxq_full),
        .bus_req(bus_req), .fifo_addr(fifo_addr), .oe_n(oe_n), .rd_n(rd_n),
        .rxq_wr(rxq_wr), .rxq_data(rxq_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'(seed + i * 7);
            ep_mem[ep_wr % 1024] = b;
            exp_q.push_back(b);
            ep_wr++;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ep_rd == ep_wr && !bus_req && exp_q.size() == 0) break;
        end
    endtask

    // Monitor, tick generator and arbiter model, all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_n != prev_rd) begin
                chk(oe_n == rd_n, "R6", oe_n, rd_n);
                chk(tick == 1'b1, "R9", tick, 1);
            end
            if (prev_rd && !rd_n) begin
                falls++;
                chk(fifo_addr == 2'b00, "R5", fifo_addr, 0);
                chk(gnt_age >= TICK_DIV, "R5", gnt_age, TICK_DIV);
                chk(bus_req && bus_gnt, "R4", {bus_req, bus_gnt}, 3);
                if (seen_fall && bus_req) chk(hi_len >= RELT * TICK_DIV, "R8", hi_len, RELT * TICK_DIV);
                seen_fall = 1;
                low_len = 1;
            end else if (!rd_n) begin
                low_len++;
            end
            if (!prev_rd && rd_n) begin
                chk(low_len == LOWT * TICK_DIV, "R8", low_len, LOWT * TICK_DIV);
                hi_len = 1;
            end else if (rd_n) begin
                hi_len++;
            end
            if (!bus_req) seen_fall = 0;
            if (rxq_wr) begin
                pushes++;
                if (exp_q.size() == 0) chk(0, "R7", rxq_data, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rxq_data == e, "R7", rxq_data, e);
                end
            end
            prev_rd = rd_n;
            gnt_age = bus_gnt ? gnt_age + 1 : 0;
        end
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        tick = (tick_cnt == 0);
        if (bus_req) begin
            req_age++;
            bus_gnt = (req_age > gnt_delay);
        end else begin
            req_age = 0;
            bus_gnt = 1'b0;
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(oe_n == 1'b1, "R1", oe_n, 1);
        chk(rd_n == 1'b1, "R1", rd_n, 1);
        chk(bus_req == 1'b0, "R1", bus_req, 0);
        chk(rxq_wr == 1'b0, "R1", rxq_wr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_n == 1'b1 && bus_req == 1'b0, "R1", {rd_n, bus_req}, 2);

        // R2: empty endpoint, nothing happens
        repeat (60) @(negedge clk);
        chk(falls == 0, "R2", falls, 0);
        chk(bus_req == 1'b0, "R2", bus_req, 0);

        // R7/R10: short burst, then bus released
        load(5, 8'h10);
        drain();
        chk(falls == 5, "R2", falls, 5);
        chk(bus_req == 1'b0, "R10", bus_req, 0);

        // R3: queue full blocks reads
        rxq_full = 1'b1;
        load(4, 8'h40);
        repeat (60) @(negedge clk);
        chk(falls == 5, "R3", falls, 5);
        chk(bus_req == 1'b0, "R3", bus_req, 0);
        rxq_full = 1'b0;
        drain();
        chk(pushes == 9, "R7", pushes, 9);

        // R3/R10: queue fills mid-burst
        base = pushes;
        load(20, 8'h80);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pushes >= base + 3) break;
        end
        rxq_full = 1'b1;
        repeat (80) @(negedge clk);
        chk(pushes == base + 3, "R3", pushes, base + 3);
        chk(bus_req == 1'b0, "R10", bus_req, 0);
        rxq_full = 1'b0;
        drain();

        // R5: slow grant
        gnt_delay = 12;
        load(3, 8'hC3);
        drain();
        gnt_delay = 2;

        // R7: long burst beyond 512 bytes
        load(600, 8'h05);
        drain();
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
        chk(falls == pushes, "R2", falls, pushes);
        chk(bus_req == 1'b0, "R10", bus_req, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule